// File: doc/BRIEF.md
# Receive Character Buffer with Per-Character Status

This block is the holding stage between the deframer of a serial receiver and the register that software reads. Each character arrives from the deframer with its own framing-error and parity-error indications. It is kept together with those indications in a small first-in, first-out store. The read side always shows the oldest unread character together with the flags that belong to that character. The flags of the character most recently received are not what the reader sees. A ready flag reports that unread data is present. Software drains the buffer by reading the data location until that flag drops.

Turning the receiver off clears the store on the next clock edge. Anything unread is discarded and the overrun indication is cleared. While the receiver is off, characters offered by the deframer are ignored. The store holds two characters by default. A character that arrives when the store is full is dropped, and a sticky overrun flag is raised.

Top module: `rx_char_fifo`

## Requirements
- R1: Each accepted character is stored with its data and framing-error flag. While the store is not empty, `rd_data`, `rd_frm_err` and `rd_par_err` show the oldest unread entry.
- R2: The stored parity-error flag of a character is 1 only if `push_par_bad` and `par_chk_en` were both 1 in the cycle that character was accepted.
- R3: The flags shown on the read side stay with the head character until that character is popped. After the pop they show the flags of the next character.
- R4: While `rx_en` is 0, the store is emptied at the next clock edge, `overrun` is cleared, and pushes and reads have no effect.
- R5: `rx_ready` is 1 exactly when at least one unread character is held. It rises in the cycle after an accepted push into an empty store.
- R6: Asserting `rd_stb` once per cycle while `rx_ready` is 1 drops `rx_ready` after exactly as many reads as characters were held.
- R7: A push while the store holds DEPTH characters and no pop occurs in that cycle is dropped and sets `overrun`. `overrun` stays 1 until `rx_en` goes to 0 or reset.
- R8: A read while the store is empty changes nothing. `rd_data` keeps the value of the last popped character (0 after reset), and both read flags are 0.
- R9: A push and a pop in the same cycle are both honoured. On a non-empty store the occupancy stays the same. On an empty store only the push takes effect.
- R10: After synchronous reset (`rst_n` 0 at a clock edge) the store is empty, `overrun` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable; 0 flushes the store |
| push_vld | input | 1 | Deframer offers a character this cycle |
| push_data | input | DATA_W | Received character |
| push_frm_err | input | 1 | Framing error of the offered character |
| push_par_bad | input | 1 | Parity mismatch of the offered character |
| par_chk_en | input | 1 | Parity checking enabled |
| rd_stb | input | 1 | Read strobe; pops the head character |
| rd_data | output | DATA_W | Head character, or last popped value when empty |
| rd_frm_err | output | 1 | Framing error of the head character |
| rd_par_err | output | 1 | Parity error of the head character |
| rx_ready | output | 1 | Unread data present |
| overrun | output | 1 | Sticky: a character was dropped while full |

## Verification
On every cycle the assertions check the following: the flush when the receiver is disabled, the stickiness and clearing of overrun, that read flags are quiet while the store is empty, that an empty read leaves the data unchanged, and that the ready flag rises only after an accepted push. Some behaviours depend on character order and content, and only the bench scenarios can show them. These are that the head flags belong to the oldest character, that parity gating is captured at push time, that a simultaneous push and pop keeps the occupancy, and that a drain loop ends after exactly the number of characters held.

// File: rtl/rxbuf_pkg.sv
// Package: shared types for the receive character buffer.
// Assumes: data width is a module parameter, so only the flag pair is typed here.
package rxbuf_pkg;

    // Error indications stored alongside every character
    typedef struct packed {
        logic frm;
        logic par;
    } rx_flags_t;

endpackage

// File: rtl/rxbuf_ctrl.sv
// Module: rxbuf_ctrl
// Keeps occupancy, write and read pointers, and the sticky overrun flag.
// Decides each cycle whether a push and/or a pop is accepted.
// Assumes: DEPTH >= 2. Disabling the receiver acts like a synchronous clear.
module rxbuf_ctrl #(
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             push_vld,
    input  logic             rd_stb,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             pop_en,
    output logic             not_empty,
    output logic             overrun
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             room;
    logic             drop;

    // Accept decisions: pop needs data, push needs room (a same-cycle pop frees one slot)
    always_comb begin
        pop_en    = rx_en && rd_stb && (cnt_q != '0);
        room      = (cnt_q != FULL_CNT) || pop_en;
        wr_en     = rx_en && push_vld && room;
        drop      = rx_en && push_vld && !room;
        not_empty = (cnt_q != '0);
    end

    // Occupancy and pointer update, cleared by reset or receiver disable
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            cnt_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(wr_en) - CNT_W'(pop_en);
            if (wr_en)
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop_en)
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Sticky overrun: set on a dropped push, cleared only by reset or disable
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en)
            overrun <= 1'b0;
        else if (drop)
            overrun <= 1'b1;
    end

endmodule

// File: rtl/rxbuf_store.sv
// Module: rxbuf_store
// Register array of DEPTH slots, each holding a character and its flags.
// Has one write port and one combinational read port.
// Assumes: pointers stay below DEPTH, and the controller gates wr_en.
module rxbuf_store
    import rxbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  rx_flags_t         wr_flags,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] head_data,
    output rx_flags_t         head_flags
);

    logic      [DEPTH-1:0][DATA_W-1:0] slot_data;
    rx_flags_t [DEPTH-1:0]             slot_flags;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] d_q;
        rx_flags_t         f_q;

        // Slot write: capture character and flags when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                f_q <= '0;
            end else if (wr_en && (wr_ptr == PTR_W'(i))) begin
                d_q <= wr_data;
                f_q <= wr_flags;
            end
        end

        assign slot_data[i]  = d_q;
        assign slot_flags[i] = f_q;
    end

    // Head read mux
    always_comb begin
        head_data  = slot_data[rd_ptr];
        head_flags = slot_flags[rd_ptr];
    end

endmodule

// File: rtl/rxbuf_outsel.sv
// Module: rxbuf_outsel
// Drives the reader-facing outputs. It shows the head entry while data is
// present. Otherwise it shows the last popped value with quiet flags.
// Assumes: pop_en is only high when not_empty is high.
module rxbuf_outsel
    import rxbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_en,
    input  logic              not_empty,
    input  logic [DATA_W-1:0] head_data,
    input  rx_flags_t         head_flags,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_frm_err,
    output logic              rd_par_err
);

    logic [DATA_W-1:0] last_q;

    // Remember the value handed out by the most recent pop
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else if (pop_en)
            last_q <= head_data;
    end

    // Output select: live head, or held value with cleared flags
    always_comb begin
        if (not_empty) begin
            rd_data    = head_data;
            rd_frm_err = head_flags.frm;
            rd_par_err = head_flags.par;
        end else begin
            rd_data    = last_q;
            rd_frm_err = 1'b0;
            rd_par_err = 1'b0;
        end
    end

endmodule

// File: rtl/rx_char_fifo.sv
// Module: rx_char_fifo (top)
// Receive buffer between a deframer and a register-read interface. Characters
// are stored with their own error flags, and the head entry's flags are shown
// to the reader. Clearing rx_en flushes the buffer.
// Assumes: push and read strobes are single-cycle qualifiers on clk.
module rx_char_fifo
    import rxbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              push_vld,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_frm_err,
    input  logic              push_par_bad,
    input  logic              par_chk_en,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_frm_err,
    output logic              rd_par_err,
    output logic              rx_ready,
    output logic              overrun
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              wr_en;
    logic              pop_en;
    logic              not_empty;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    rx_flags_t         wr_flags;
    rx_flags_t         head_flags;
    logic [DATA_W-1:0] head_data;

    // Flags for storage: parity only counts when checking is enabled now
    always_comb begin
        wr_flags.frm = push_frm_err;
        wr_flags.par = push_par_bad && par_chk_en;
    end

    rxbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .push_vld  (push_vld),
        .rd_stb    (rd_stb),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .pop_en    (pop_en),
        .not_empty (not_empty),
        .overrun   (overrun)
    );

    rxbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_ptr     (wr_ptr),
        .wr_data    (push_data),
        .wr_flags   (wr_flags),
        .rd_ptr     (rd_ptr),
        .head_data  (head_data),
        .head_flags (head_flags)
    );

    rxbuf_outsel #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_en     (pop_en),
        .not_empty  (not_empty),
        .head_data  (head_data),
        .head_flags (head_flags),
        .rd_data    (rd_data),
        .rd_frm_err (rd_frm_err),
        .rd_par_err (rd_par_err)
    );

    assign rx_ready = not_empty;

endmodule

// File: rtl/rx_char_fifo_chk.sv
// Module: rx_char_fifo_chk
// Checker bound to rx_char_fifo. Its properties relate only port
// behaviour over time.
module rx_char_fifo_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              push_vld,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_frm_err,
    input logic              rd_par_err,
    input logic              rx_ready,
    input logic              overrun
);

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_ready);                                        // R4

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !overrun);                                         // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && overrun) |=> overrun);                              // R7

    AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> (!rd_frm_err && !rd_par_err));                  // R8

    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && rd_stb && !(rx_en && push_vld)) |=> (!rx_ready && $stable(rd_data))); // R8

    AST_READY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(rx_en && push_vld));                // R5

endmodule

bind rx_char_fifo rx_char_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .push_vld   (push_vld),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .rd_frm_err (rd_frm_err),
    .rd_par_err (rd_par_err),
    .rx_ready   (rx_ready),
    .overrun    (overrun)
);

// File: tb/rx_char_fifo_test.sv
module rx_char_fifo_test;

    localparam int CLK_P = 10;
    localparam int W     = 8;

    typedef struct packed {
        logic         en;
        logic         push;
        logic [W-1:0] d;
        logic         fe;
        logic         pb;
        logic         pe;
        logic         rd;
        logic         x_rdy;
        logic         x_ovr;
        logic [W-1:0] x_d;
        logic         x_pe;
        logic         x_fe;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 14;
    // en push data fe pb pe rd | rdy ovr data perr ferr | req
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,8'hA5,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,8'hA5,1'b1,1'b0, 4'd2},  // R2 gated parity kept
        '{1'b1,1'b1,8'h3C,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0,8'hA5,1'b1,1'b0, 4'd1},  // R1 head unchanged
        '{1'b1,1'b1,8'h77,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,8'hA5,1'b1,1'b0, 4'd7},  // R7 full drop
        '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1,8'h3C,1'b0,1'b1, 4'd3},  // R3 next flags, par gated off
        '{1'b1,1'b1,8'h11,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b1,8'h11,1'b0,1'b0, 4'd9},  // R9 push+pop
        '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,8'h11,1'b0,1'b0, 4'd5},  // R5 empty
        '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,8'h11,1'b0,1'b0, 4'd8},  // R8 empty read
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h11,1'b0,1'b0, 4'd4},  // R4 ovr cleared
        '{1'b0,1'b1,8'h99,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,8'h11,1'b0,1'b0, 4'd4},  // R4 push ignored
        '{1'b1,1'b1,8'h5A,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,8'h5A,1'b1,1'b0, 4'd1},  // R1
        '{1'b1,1'b1,8'h6B,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,8'h5A,1'b1,1'b0, 4'd3},  // R3
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h11,1'b0,1'b0, 4'd4},  // R4 flush full
        '{1'b1,1'b1,8'hC3,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,8'hC3,1'b0,1'b1, 4'd5},  // R5 after flush
        '{1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'hC3,1'b0,1'b0, 4'd8}   // R8 last value
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_en = 1'b0;
    logic         push_vld = 1'b0;
    logic [W-1:0] push_data = '0;
    logic         push_frm_err = 1'b0;
    logic         push_par_bad = 1'b0;
    logic         par_chk_en = 1'b0;
    logic         rd_stb = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_frm_err;
    logic         rd_par_err;
    logic         rx_ready;
    logic         overrun;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rx_char_fifo #(.DATA_W(W), .DEPTH(2)) uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_vld(push_vld),
        .push_data(push_data), .push_frm_err(push_frm_err),
        .push_par_bad(push_par_bad), .par_chk_en(par_chk_en), .rd_stb(rd_stb),
        .rd_data(rd_data), .rd_frm_err(rd_frm_err), .rd_par_err(rd_par_err),
        .rx_ready(rx_ready), .overrun(overrun)
    );

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic expect_out(string tag, logic rdy, logic ovr, logic [W-1:0] d,
                              logic pe, logic fe);
        checks++;
        if (rx_ready !== rdy || overrun !== ovr || rd_data !== d ||
            rd_par_err !== pe || rd_frm_err !== fe) begin
            errors++;
            $display("FAIL %s: got rdy=%b ovr=%b d=%h pe=%b fe=%b expected rdy=%b ovr=%b d=%h pe=%b fe=%b",
                     tag, rx_ready, overrun, rd_data, rd_par_err, rd_frm_err,
                     rdy, ovr, d, pe, fe);
        end
    endtask

    task automatic idle_inputs();
        push_vld = 1'b0; rd_stb = 1'b0; push_frm_err = 1'b0;
        push_par_bad = 1'b0; par_chk_en = 1'b0; push_data = '0;
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int reads;
        tick();
        tick();
        expect_out("R10 reset", 1'b0, 1'b0, '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        rx_en = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            rx_en = VEC[i].en; push_vld = VEC[i].push; push_data = VEC[i].d;
            push_frm_err = VEC[i].fe; push_par_bad = VEC[i].pb;
            par_chk_en = VEC[i].pe; rd_stb = VEC[i].rd;
            tick();
            expect_out($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].x_rdy,
                       VEC[i].x_ovr, VEC[i].x_d, VEC[i].x_pe, VEC[i].x_fe);
        end
        idle_inputs();
        rx_en = 1'b1;
        tick();

        // R6 drain: fill with three pushes (third overruns), then read until empty
        for (int k = 0; k < 3; k++) begin
            push_vld = 1'b1; push_data = 8'h20 + W'(k);
            tick();
        end
        push_vld = 1'b0;
        reads = 0;
        while (rx_ready && reads < 10) begin
            rd_stb = 1'b1;
            tick();
            reads++;
        end
        rd_stb = 1'b0;
        checks++;
        if (reads != 2) begin
            errors++;
            $display("FAIL R6 drain reads: got %0d expected 2", reads);
        end
        expect_out("R6 drained, R7 sticky", 1'b0, 1'b1, 8'h21, 1'b0, 1'b0);

        // R9 push and read together on an empty store: push only
        push_vld = 1'b1; rd_stb = 1'b1; push_data = 8'h42;
        tick();
        idle_inputs();
        expect_out("R9 empty push+read", 1'b1, 1'b1, 8'h42, 1'b0, 1'b0);

        // R10 reset while holding data
        rst_n = 1'b0;
        tick();
        expect_out("R10 mid reset", 1'b0, 1'b0, '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule